// File: doc/BRIEF.md
# Register Space Decoder with Bus Timeout

This block sits between a processor's register-space access port and the targets that answer it. Each access presents a physical address, a read or write direction, byte enables and write data for one cycle. The block compares the address against a fixed, ordered table of address ranges and raises the select strobe of the first range that can serve the access. For reads it returns that target's data. The targets themselves are outside the block. Each one contributes only a read-data word and receives only a strobe.

One range is served inside the block. It holds three registers of a system support unit: a relocatable base register, a configuration register with a battery-low flag, and a bus timeout register. An access that no range claims sets sticky flags in the timeout register and produces a single-cycle machine-check pulse. An unclaimed read returns zero.

A second, independent path accepts processor-register numbers. Each number is looked up in two parameter bitmaps, one for reads and one for writes. A known number produces a select strobe. An unknown number sets only the timeout flag, with no machine check.

Top module: `regspace_decoder`

## Requirements
- R1: Ranges are tried in table order (index 0 MAP 0x20080000-0x20087FFF, 1 ROM, 2 LOCAL 0x20140000-0x201403FF, 3 NVR 0x20140400-0x201407FF, 4 DIAG 0x20100000-0x201FFFFF, 5 CTRL 0x20000000-0x20000FFF), and only the first range that claims the access raises its bit of `tgt_sel`. For a read, `acc_rdata` is that range's 32-bit slice of `tgt_rdata` (slice i is bits 32*i+31:32*i), or the local register value for LOCAL.
- R2: A range claims a read only if it is read-capable and a write only if it is write-capable. DIAG is write-only and ROM is read-only; every other range takes both.
- R3: The ROM range spans twice the ROM size (0x20040000-0x2007FFFF for a 0x20000-byte ROM), so the ROM contents appear twice.
- R4: An access that no range claims raises no select, returns zero on a read, sets timeout bits 31 and 30, and drives `mchk` high for exactly the cycle after the access.
- R5: An IPR access whose number is absent from the bitmap for its direction sets only timeout bit 31 and raises no `mchk`. A known number raises `ipr_sel` in the same cycle. Read-known numbers are 0x18, 0x1B-0x23. Write-known numbers are those plus 0x37.
- R6: The timeout register is at local byte offset 0x20. Bits 31 and 30 are write-one-to-clear, bits 23:0 are read/write, and all other bits read zero. A flag set in the same cycle as its clear ends up set, and a set flag stays set until it is cleared.
- R7: The base register is at offset 0x00. Bits 28:10 are writable, bit 29 reads one, all other bits read zero, and the reset value is 0x20140000.
- R8: The configuration register is at offset 0x10. Bit 31 is write-one-to-clear, the bits in mask 0x0BF7F777 are read/write, all other bits read zero, and reset clears every bit except battery low.
- R9: Battery low (configuration bit 31) is set from the first clock after reset if `nvr_present` is low, is set when `nvr_present` falls, and is cleared when it rises.
- R10: A write with fewer than four byte enables first merges the register's current read value with the enabled lanes of `acc_wdata`, then applies the field rules. A write-one-to-clear flag therefore clears whenever it reads one, even if its own lane is not enabled.
- R11: Local offsets other than 0x00, 0x10 and 0x20 are claimed, read as zero, and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register-space access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Physical byte address |
| acc_be | input | 4 | Byte-lane enables (bit n = bits 8n+7:8n) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the current access (zero on writes and misses) |
| tgt_sel | output | 6 | One select strobe per range, first match only |
| tgt_rdata | input | 192 | Read data of each range, 32 bits per range |
| mchk | output | 1 | Machine-check pulse, the cycle after an unclaimed access |
| ipr_valid | input | 1 | Processor-register access this cycle |
| ipr_write | input | 1 | 1 = IPR write, 0 = IPR read |
| ipr_num | input | 6 | Processor-register number |
| ipr_sel | output | 1 | Known IPR number strobe |
| nvr_present | input | 1 | Non-volatile store attached |

## Verification
Addresses are chosen to tell apart the cases that matter. Some lie where two ranges overlap, and decode must pick the earlier one. Some lie on range edges, and decode must respect the exclusive upper bound. Some lie in the second copy of the ROM, and some sit in a range that cannot serve the current direction. Misses are produced on both the memory-mapped and the IPR path so that their different flag and machine-check effects can be told apart. One case drives an IPR miss in the same cycle as a write that clears the timeout flag, to show which one wins. Sub-longword writes are aimed at lanes that do not hold a set flag, which shows that the merge happens before the field rules.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

   localparam int NRANGE    = 6;
   localparam int LOCAL_IDX = 2;
   localparam int DW        = 32;

   localparam logic [31:0] ROM_LO    = 32'h2004_0000;
   localparam logic [31:0] ROM_BYTES = 32'h0002_0000;

   // ordered table: lower index wins
   localparam logic [31:0] RNG_LO [NRANGE] = '{
      32'h2008_0000, ROM_LO, 32'h2014_0000,
      32'h2014_0400, 32'h2010_0000, 32'h2000_0000};
   localparam logic [31:0] RNG_HI [NRANGE] = '{
      32'h2008_8000, ROM_LO + (ROM_BYTES << 1), 32'h2014_0400,
      32'h2014_0800, 32'h2020_0000, 32'h2000_1000};
   localparam logic [NRANGE-1:0] RNG_CAN_RD = 6'b101111;
   localparam logic [NRANGE-1:0] RNG_CAN_WR = 6'b111101;

   // local register word indices
   localparam logic [7:0] LW_BASE = 8'h00;
   localparam logic [7:0] LW_CONF = 8'h04;
   localparam logic [7:0] LW_TMO  = 8'h08;

   localparam logic [31:0] BASE_ONE  = 32'h2000_0000;
   localparam logic [31:0] BASE_RST  = 32'h2014_0000;
   localparam logic [31:0] CNF_RW    = 32'h0BF7_F777;
   localparam logic [23:0] TMO_IVAL0 = 24'h0;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
      return m;
   endfunction

endpackage

// File: rtl/rsd_range_match.sv
module rsd_range_match
   import rsd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              is_wr,
   input  logic [31:0]       addr,
   output logic [NRANGE-1:0] hit,
   output logic              claimed
);

   logic [NRANGE-1:0] raw;

   for (genvar i = 0; i < NRANGE; i++) begin : g_rng
      if (RNG_HI[i] <= RNG_LO[i]) begin : g_bad
         $error("range %0d has an empty span", i);
      end
      assign raw[i] = (addr >= RNG_LO[i]) && (addr < RNG_HI[i]) &&
                      (is_wr ? RNG_CAN_WR[i] : RNG_CAN_RD[i]);
   end

   always_comb begin
      logic found;
      found = 1'b0;
      hit   = '0;
      for (int i = 0; i < NRANGE; i++) begin
         if (raw[i] && !found) begin
            hit[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   assign claimed = |hit;

   // R1: at most one winner, and a winner implies a candidate
   a_r1_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ($onehot0(hit) && ((hit & ~raw) == '0)));

   // R2: a direction-incapable range never wins
   a_r2_capability: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> ((hit & (is_wr ? ~RNG_CAN_WR : ~RNG_CAN_RD)) == '0));

endmodule

// File: rtl/rsd_ipr_check.sv
module rsd_ipr_check #(
   parameter int                     IPR_W    = 6,
   parameter logic [(1<<IPR_W)-1:0]  KNOWN_RD = '0,
   parameter logic [(1<<IPR_W)-1:0]  KNOWN_WR = '0
) (
   input  logic             valid,
   input  logic             write,
   input  logic [IPR_W-1:0] num,
   output logic             sel,
   output logic             unknown
);

   if (IPR_W < 1 || IPR_W > 8) begin : g_bad_w
      $error("IPR_W must be 1..8");
   end

   logic known;
   assign known   = write ? KNOWN_WR[num] : KNOWN_RD[num];
   assign sel     = valid & known;
   assign unknown = valid & ~known;

endmodule

// File: rtl/rsd_local_regs.sv
module rsd_local_regs
   import rsd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  widx,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   input  logic        set_to,
   input  logic        set_rw,
   input  logic        nvr_present,
   output logic [31:0] rdata
);

   logic [18:0] base_f;
   logic [31:0] cnf_rw;
   logic        cnf_blo;
   logic        to_flag;
   logic        rw_flag;
   logic [23:0] to_ival;
   logic        nvr_q;

   logic [31:0] rd_base, rd_cnf, rd_tmo, merged, lm;
   logic        wr_base, wr_cnf, wr_tmo, nvr_rise, nvr_fall;

   assign rd_base = BASE_ONE | {3'b000, base_f, 10'b0};
   assign rd_cnf  = {cnf_blo, 31'b0} | cnf_rw;
   assign rd_tmo  = {to_flag, rw_flag, 6'b0, to_ival};

   always_comb begin
      unique case (widx)
         LW_BASE: rdata = rd_base;
         LW_CONF: rdata = rd_cnf;
         LW_TMO:  rdata = rd_tmo;
         default: rdata = '0;
      endcase
   end

   assign lm      = lane_mask(be);
   assign merged  = (rdata & ~lm) | (wdata & lm);
   assign wr_base = wr_en && (widx == LW_BASE);
   assign wr_cnf  = wr_en && (widx == LW_CONF);
   assign wr_tmo  = wr_en && (widx == LW_TMO);
   assign nvr_rise = nvr_present & ~nvr_q;
   assign nvr_fall = ~nvr_present & nvr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_f  <= BASE_RST[28:10];
         cnf_rw  <= '0;
         cnf_blo <= 1'b0;
         to_flag <= 1'b0;
         rw_flag <= 1'b0;
         to_ival <= TMO_IVAL0;
         nvr_q   <= 1'b1;
      end else begin
         nvr_q <= nvr_present;
         if (wr_base) base_f <= merged[28:10];
         if (wr_cnf)  cnf_rw <= merged & CNF_RW;
         if (nvr_fall)                     cnf_blo <= 1'b1;
         else if (nvr_rise)                cnf_blo <= 1'b0;
         else if (wr_cnf && merged[31])    cnf_blo <= 1'b0;
         if (wr_tmo) to_ival <= merged[23:0];
         to_flag <= set_to | (to_flag & ~(wr_tmo & merged[31]));
         rw_flag <= set_rw | (rw_flag & ~(wr_tmo & merged[30]));
      end
   end

   // R6: a set in the same cycle as a clear leaves the flag set
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_to |=> to_flag);
   // R6: sticky until written
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (to_flag && !wr_tmo) |=> to_flag);
   // R4: a memory-path miss marks the read/write flag
   a_r4_rw_flag: assert property (@(posedge clk) disable iff (!rst_n)
      set_rw |=> (rw_flag && to_flag));
   // R9: attach clears battery low, detach sets it
   a_r9_attach_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (nvr_present && !nvr_q) |=> !cnf_blo);
   a_r9_detach_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!nvr_present && nvr_q) |=> cnf_blo);

endmodule

// File: rtl/regspace_decoder.sv
module regspace_decoder
   import rsd_pkg::*;
#(
   parameter int                    IPR_W        = 6,
   parameter logic [(1<<IPR_W)-1:0] IPR_KNOWN_RD = 64'h0000_000F_F900_0000,
   parameter logic [(1<<IPR_W)-1:0] IPR_KNOWN_WR = 64'h0080_000F_F900_0000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic                 acc_write,
   input  logic [31:0]          acc_addr,
   input  logic [3:0]           acc_be,
   input  logic [31:0]          acc_wdata,
   output logic [31:0]          acc_rdata,
   output logic [NRANGE-1:0]    tgt_sel,
   input  logic [NRANGE*DW-1:0] tgt_rdata,
   output logic                 mchk,
   input  logic                 ipr_valid,
   input  logic                 ipr_write,
   input  logic [IPR_W-1:0]     ipr_num,
   output logic                 ipr_sel,
   input  logic                 nvr_present
);

   logic [NRANGE-1:0] hit;
   logic              claimed, miss, ipr_unknown;
   logic [31:0]       local_rdata, ext_rdata;
   logic              mchk_q;

   rsd_range_match i_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (acc_valid),
      .is_wr   (acc_write),
      .addr    (acc_addr),
      .hit     (hit),
      .claimed (claimed)
   );

   rsd_ipr_check #(
      .IPR_W    (IPR_W),
      .KNOWN_RD (IPR_KNOWN_RD),
      .KNOWN_WR (IPR_KNOWN_WR)
   ) i_ipr (
      .valid   (ipr_valid),
      .write   (ipr_write),
      .num     (ipr_num),
      .sel     (ipr_sel),
      .unknown (ipr_unknown)
   );

   assign miss = acc_valid & ~claimed;

   rsd_local_regs i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (acc_valid & acc_write & hit[LOCAL_IDX]),
      .widx        (acc_addr[9:2]),
      .be          (acc_be),
      .wdata       (acc_wdata),
      .set_to      (miss | ipr_unknown),
      .set_rw      (miss),
      .nvr_present (nvr_present),
      .rdata       (local_rdata)
   );

   always_comb begin
      ext_rdata = '0;
      for (int i = 0; i < NRANGE; i++)
         if (hit[i]) ext_rdata = tgt_rdata[DW*i +: DW];
   end

   assign tgt_sel   = acc_valid ? hit : '0;
   assign acc_rdata = (!acc_valid || acc_write) ? '0 :
                      hit[LOCAL_IDX] ? local_rdata : ext_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mchk_q <= 1'b0;
      else        mchk_q <= miss;
   end
   assign mchk = mchk_q;

   // R4: an unclaimed access is followed by a machine-check pulse
   a_r4_mchk_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !claimed) |=> mchk);
   // R5: without a memory-path miss, no machine check, whatever the IPR path does
   a_r5_no_mchk_from_ipr: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && !claimed) |=> !mchk);
   // R4: unclaimed reads return zero
   a_r4_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && tgt_sel == '0) |-> (acc_rdata == '0));

endmodule

// File: tb/test_regspace_decoder.sv
module test_regspace_decoder;
   import rsd_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 0, acc_write = 0;
   logic [31:0] acc_addr = '0, acc_wdata = '0, acc_rdata;
   logic [3:0]  acc_be = '0;
   logic [5:0]  tgt_sel;
   logic [NRANGE*32-1:0] tgt_rdata;
   logic mchk, ipr_sel;
   logic ipr_valid = 0, ipr_write = 0;
   logic [5:0] ipr_num = '0;
   logic nvr_present = 1'b0;

   int checks = 0, errors = 0;

   localparam logic [31:0] A_BASE = 32'h2014_0000;
   localparam logic [31:0] A_CONF = 32'h2014_0010;
   localparam logic [31:0] A_TMO  = 32'h2014_0020;

   always #5 clk = ~clk;

   for (genvar i = 0; i < NRANGE; i++) begin : g_td
      assign tgt_rdata[32*i +: 32] = 32'hA5A5_0000 + i;
   end

   regspace_decoder i_regspace_decoder (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .tgt_sel(tgt_sel), .tgt_rdata(tgt_rdata),
      .mchk(mchk), .ipr_valid(ipr_valid), .ipr_write(ipr_write),
      .ipr_num(ipr_num), .ipr_sel(ipr_sel), .nvr_present(nvr_present));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [31:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output logic [5:0] sel, output logic mc);
      @(negedge clk);
      acc_valid = 1; acc_write = wr; acc_addr = addr; acc_be = be; acc_wdata = wd;
      #1 rd = acc_rdata; sel = tgt_sel;
      @(negedge clk);
      acc_valid = 0; acc_write = 0;
      mc = mchk;
   endtask

   task automatic wr32(input logic [31:0] addr, input logic [31:0] wd);
      logic [31:0] rd; logic [5:0] s; logic m;
      access(1, addr, 4'hF, wd, rd, s, m);
   endtask

   task automatic rd32(input logic [31:0] addr, output logic [31:0] rd);
      logic [5:0] s; logic m;
      access(0, addr, 4'hF, '0, rd, s, m);
   endtask

   task automatic ipr_op(input bit wr, input logic [5:0] num, output logic sel, output logic mc);
      @(negedge clk);
      ipr_valid = 1; ipr_write = wr; ipr_num = num;
      #1 sel = ipr_sel;
      @(negedge clk);
      ipr_valid = 0;
      mc = mchk;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      check("R4 reset mchk", {31'b0, mchk}, 0);
      rd32(A_TMO, v);  check("R6 reset timeout", v, 32'h0);
      rd32(A_CONF, v); check("R8/R9 reset config battery low", v, 32'h8000_0000);
      rd32(A_BASE, v); check("R7 reset base", v, 32'h2014_0000);
   endtask

   task automatic t_priority;
      logic [31:0] r; logic [5:0] s; logic m;
      access(0, 32'h2008_0004, 4'hF, 0, r, s, m);
      check("R1 MAP select", {26'b0, s}, 6'b000001); check("R1 MAP data", r, 32'hA5A5_0000);
      access(0, A_CONF, 4'hF, 0, r, s, m);
      check("R1 LOCAL wins over DIAG", {26'b0, s}, 6'b000100);
      access(1, 32'h2014_0400, 4'hF, 0, r, s, m);
      check("R1 NVR wins over DIAG", {26'b0, s}, 6'b001000);
      access(1, 32'h2015_0000, 4'hF, 0, r, s, m);
      check("R1 DIAG write", {26'b0, s}, 6'b010000); check("R1 no mchk", {31'b0, m}, 0);
      access(0, 32'h2000_0FFC, 4'hF, 0, r, s, m);
      check("R1 CTRL select", {26'b0, s}, 6'b100000); check("R1 CTRL data", r, 32'hA5A5_0005);
   endtask

   task automatic t_handlers;
      logic [31:0] r; logic [5:0] s; logic m;
      access(0, 32'h2018_0000, 4'hF, 0, r, s, m);
      check("R2 DIAG read unclaimed sel", {26'b0, s}, 0);
      check("R2 DIAG read mchk", {31'b0, m}, 1);
      access(1, 32'h2004_0000, 4'hF, 32'h1234, r, s, m);
      check("R2 ROM write unclaimed sel", {26'b0, s}, 0);
      check("R2 ROM write mchk", {31'b0, m}, 1);
      wr32(A_TMO, 32'hC000_0000);
   endtask

   task automatic t_rom;
      logic [31:0] r; logic [5:0] s; logic m;
      access(0, 32'h2006_0000, 4'hF, 0, r, s, m);
      check("R3 ROM second copy", {26'b0, s}, 6'b000010); check("R3 ROM data", r, 32'hA5A5_0001);
      access(0, 32'h2007_FFFC, 4'hF, 0, r, s, m);
      check("R3 ROM top word", {26'b0, s}, 6'b000010);
      access(0, 32'h2003_FFFC, 4'hF, 0, r, s, m);
      check("R3 below ROM misses", {31'b0, m}, 1);
      wr32(A_TMO, 32'hC000_0000);
   endtask

   task automatic t_miss;
      logic [31:0] r, v; logic [5:0] s; logic m;
      access(0, 32'h3000_0000, 4'hF, 0, r, s, m);
      check("R4 miss reads zero", r, 0);
      check("R4 mchk pulse", {31'b0, m}, 1);
      @(negedge clk);
      check("R4 mchk one cycle", {31'b0, mchk}, 0);
      rd32(A_TMO, v); check("R4 both flags", v, 32'hC000_0000);
      wr32(A_TMO, 32'hC000_0000);
   endtask

   task automatic t_timeout;
      logic [31:0] v;
      wr32(A_TMO, 32'hFFFF_FFFF);
      rd32(A_TMO, v); check("R6 fields", v, 32'h00FF_FFFF);
      @(negedge clk);
      acc_valid = 1; acc_write = 1; acc_addr = A_TMO; acc_be = 4'hF; acc_wdata = 32'h8000_0000;
      ipr_valid = 1; ipr_write = 0; ipr_num = 6'h05;
      @(negedge clk);
      acc_valid = 0; ipr_valid = 0;
      rd32(A_TMO, v); check("R6 set wins over clear", v, 32'h8000_0000);
      wr32(A_TMO, 32'h8000_0000);
      rd32(A_TMO, v); check("R6 clear", v, 32'h0);
   endtask

   task automatic t_ipr;
      logic [31:0] v; logic s, m;
      ipr_op(0, 6'h05, s, m);
      check("R5 unknown no sel", {31'b0, s}, 0); check("R5 unknown no mchk", {31'b0, m}, 0);
      rd32(A_TMO, v); check("R5 only bit31", v, 32'h8000_0000);
      wr32(A_TMO, 32'h8000_0000);
      ipr_op(0, 6'h1C, s, m); check("R5 known read sel", {31'b0, s}, 1);
      rd32(A_TMO, v); check("R5 known leaves timeout", v, 0);
      ipr_op(1, 6'h37, s, m); check("R5 write-only known", {31'b0, s}, 1);
      ipr_op(0, 6'h37, s, m); check("R5 read of write-only", {31'b0, s}, 0);
      rd32(A_TMO, v); check("R5 read unknown flag", v, 32'h8000_0000);
      wr32(A_TMO, 32'h8000_0000);
   endtask

   task automatic t_base;
      logic [31:0] v;
      wr32(A_BASE, 32'hFFFF_FFFF); rd32(A_BASE, v); check("R7 all ones", v, 32'h3FFF_FC00);
      wr32(A_BASE, 32'h0);         rd32(A_BASE, v); check("R7 bit29 fixed", v, 32'h2000_0000);
      wr32(A_BASE, 32'h2014_0000);
   endtask

   task automatic t_config;
      logic [31:0] v;
      wr32(A_CONF, 32'hFFFF_FFFF); rd32(A_CONF, v); check("R8 rw mask and w1c", v, 32'h0BF7_F777);
      wr32(A_CONF, 32'h0);         rd32(A_CONF, v); check("R8 clear", v, 32'h0);
   endtask

   task automatic t_nvr;
      logic [31:0] v;
      @(negedge clk); nvr_present = 1; repeat (2) @(negedge clk);
      @(negedge clk); nvr_present = 0; repeat (2) @(negedge clk);
      rd32(A_CONF, v); check("R9 detach sets", v, 32'h8000_0000);
      @(negedge clk); nvr_present = 1; repeat (2) @(negedge clk);
      rd32(A_CONF, v); check("R9 attach clears", v, 32'h0);
   endtask

   task automatic t_merge;
      logic [31:0] r, v; logic [5:0] s; logic m, is, im;
      wr32(A_TMO, 32'h00AB_CDEF);
      ipr_op(0, 6'h02, is, im);
      rd32(A_TMO, v); check("R10 setup", v, 32'h80AB_CDEF);
      access(1, A_TMO, 4'b0001, 32'h0000_0012, r, s, m);
      rd32(A_TMO, v); check("R10 byte write merges and clears", v, 32'h00AB_CD12);
      access(1, A_TMO, 4'b0100, 32'h0077_0000, r, s, m);
      rd32(A_TMO, v); check("R10 lane 2", v, 32'h0077_CD12);
      access(1, A_CONF, 4'b0001, 32'hFFFF_FFFF, r, s, m);
      rd32(A_CONF, v); check("R10 config low byte", v, 32'h0000_0077);
   endtask

   task automatic t_unused;
      logic [31:0] r, v; logic [5:0] s; logic m;
      access(1, 32'h2014_0040, 4'hF, 32'hFFFF_FFFF, r, s, m);
      check("R11 claimed", {26'b0, s}, 6'b000100); check("R11 no mchk", {31'b0, m}, 0);
      rd32(32'h2014_0040, v); check("R11 reads zero", v, 0);
      rd32(A_BASE, v);        check("R11 base untouched", v, 32'h2014_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      t_reset;
      t_priority;
      t_handlers;
      t_rom;
      t_miss;
      t_timeout;
      t_ipr;
      t_base;
      t_config;
      t_nvr;
      t_merge;
      t_unused;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule